// File: doc/BRIEF.md
# Stack high water mark tracker

This block keeps two 32-bit control registers: a watermark and a watermark base. It watches the store addresses that leave a processor's memory stage. Whenever a store lands inside the window from the base (inclusive) up to the current watermark (exclusive), the watermark drops to that address, rounded down to a 16-byte boundary. Set the base to the bottom of a stack region and the watermark to a point inside it. The watermark then follows the lowest stack address written below its starting value. Stacks grow downward, so that value shows how deep the stack was used, and a task switcher can clear only the part of the stack that was touched.

Software reaches both registers through a CSR access port. That port carries a 12-bit CSR number, write data, write and read strobes, and one permission bit supplied from outside. An access to either register without permission is refused: the block raises an illegal-access flag, returns zero and changes nothing. Both stored values always have their four low bits clear. Only the starting byte address of a store is compared. The width of the store is never seen.

Top module: `stack_watermark`

## Requirements
- R1: The watermark is at CSR number 0xBC1 and the base at 0xBC2. A permitted read of either returns its stored value on `csr_rdata` in the same cycle. CSR numbers other than these two return zero, never raise `csr_illegal` and change nothing.
- R2: An access (read or write strobe) to 0xBC1 or 0xBC2 with `csr_perm` low raises `csr_illegal` during that cycle, returns zero on `csr_rdata` and leaves both registers unchanged.
- R3: Bits 3..0 of both registers always read as zero.
- R4: A permitted CSR write stores the write data with bits 3..0 cleared. In the same cycle, `csr_rdata` returns that legalised value, even when the read strobe is also high. The stored value is visible from the next clock edge.
- R5: After reset both registers read zero.
- R6: A store with `st_valid` high whose address A satisfies base <= A < watermark, compared unsigned, updates the watermark on the next clock edge. An address with bit 31 set counts as large.
- R7: The updated watermark equals A with bits 3..0 cleared.
- R8: A store with A below the base, or with A equal to or above the watermark, leaves the watermark unchanged. This holds even when a multi-byte store starting at base-1 would cover bytes at or above the base.
- R9: If a permitted CSR write to the watermark and a qualifying store happen in the same cycle, the watermark takes the legalised CSR value and the store is dropped.
- R10: With `st_valid` low, the store address has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR number of the access |
| csr_wdata | input | 32 | CSR write data |
| csr_we | input | 1 | CSR write strobe |
| csr_re | input | 1 | CSR read strobe |
| csr_perm | input | 1 | Permission to access system registers |
| csr_rdata | output | 32 | CSR read data (legalised new value on a write) |
| csr_illegal | output | 1 | Refused access to 0xBC1 or 0xBC2 |
| st_valid | input | 1 | A store is observed this cycle |
| st_addr | input | 32 | Lowest byte address of the observed store |

## Verification
The hardest cases to reach are the edges of the window: stores at exactly the base, at one byte below it, and at exactly the watermark or one byte under it. These matter most once the watermark has already moved. The bench therefore resets the watermark through the CSR port before every store. It then sweeps every byte address across a span that straddles both edges, so each address is judged against a known window. Two further cases need the CSR port and the store port driven in the same cycle: the write-versus-store collision, and a window placed above bit 31 to prove the compare is unsigned.

// File: rtl/stack_watermark.sv
module stack_watermark #(
  parameter int          XLEN     = 32,
  parameter int          ALIGN    = 4,
  parameter logic [11:0] WM_CSR   = 12'hBC1,
  parameter logic [11:0] BASE_CSR = 12'hBC2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  input  logic            csr_re,
  input  logic            csr_perm,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  input  logic            st_valid,
  input  logic [XLEN-1:0] st_addr
);

  localparam logic [XLEN-1:0] MASK = {XLEN{1'b1}} << ALIGN;

  logic [XLEN-1:0] wm_q, base_q;

  wire sel_wm   = (csr_addr == WM_CSR);
  wire sel_base = (csr_addr == BASE_CSR);
  wire sel_any  = sel_wm | sel_base;
  wire access   = csr_we | csr_re;
  wire granted  = sel_any & access & csr_perm;
  wire wr_wm    = granted & csr_we & sel_wm;
  wire wr_base  = granted & csr_we & sel_base;
  wire [XLEN-1:0] wdata_legal = csr_wdata & MASK;
  wire st_hit   = st_valid && (st_addr >= base_q) && (st_addr < wm_q);

  assign csr_illegal = sel_any & access & ~csr_perm;
  assign csr_rdata   = !granted ? '0 :
                       csr_we   ? wdata_legal :
                       sel_wm   ? wm_q : base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wm_q   <= '0;
      base_q <= '0;
    end else begin
      if (wr_wm)       wm_q <= wdata_legal;
      else if (st_hit) wm_q <= st_addr & MASK;
      if (wr_base)     base_q <= wdata_legal;
    end
  end

  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> csr_rdata[ALIGN-1:0] == '0); // R3
  AST_DENIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0); // R2
  AST_DENIED_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> base_q == $past(base_q)); // R2
  AST_WM_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_wm |=> wm_q <= $past(wm_q)); // R6
  AST_STORE_ROUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !wr_wm) |=> wm_q == ($past(st_addr) & MASK)); // R7
  AST_CSR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wm |=> wm_q == $past(wdata_legal)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !wr_wm) |=> $stable(wm_q)); // R10

endmodule

// File: tb/tb_stack_watermark.sv
module tb_stack_watermark;
  localparam logic [11:0] A_WM = 12'hBC1, A_BS = 12'hBC2;
  localparam logic [31:0] M = 32'hFFFF_FFF0;

  logic clk = 0, rst_n = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, st_addr = 0;
  logic csr_we = 0, csr_re = 0, csr_perm = 0, st_valid = 0;
  logic [31:0] csr_rdata;
  logic csr_illegal;

  int nchk = 0, nbad = 0;
  logic [31:0] wm_m = 0, bs_m = 0;

  always #5 clk = ~clk;

  stack_watermark dut (.clk, .rst_n, .csr_addr, .csr_wdata, .csr_we, .csr_re,
    .csr_perm, .csr_rdata, .csr_illegal, .st_valid, .st_addr);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [11:0] a, input logic [31:0] d,
                     input logic we, input logic re, input logic pm,
                     input logic sv, input logic [31:0] sa);
    logic hit, legal, exp_ill, qual;
    logic [31:0] exp_rd;
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = we; csr_re = re; csr_perm = pm;
    st_valid = sv; st_addr = sa;
    hit = (a == A_WM) || (a == A_BS);
    legal = hit && pm && (we || re);
    exp_ill = hit && (we || re) && !pm;
    exp_rd = !legal ? 32'h0 : we ? (d & M) : (a == A_WM ? wm_m : bs_m);
    #1;
    chk({tag, " rdata"}, csr_rdata, exp_rd);
    chk({tag, " illegal"}, {31'h0, csr_illegal}, {31'h0, exp_ill});
    qual = sv && (sa >= bs_m) && (sa < wm_m);
    if (legal && we && a == A_WM) wm_m = d & M;
    else if (qual) wm_m = sa & M;
    if (legal && we && a == A_BS) bs_m = d & M;
    @(posedge clk); #1;
    csr_we = 0; csr_re = 0; st_valid = 0;
  endtask

  task automatic rd_both(input string tag);
    cyc(tag, A_WM, 0, 0, 1, 1, 0, 0);
    cyc(tag, A_BS, 0, 0, 1, 1, 0, 0);
  endtask

  initial begin
    #2_000_000;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_both("R5 reset");

    for (int i = 0; i < 16; i++) begin
      cyc("R4 legalise wm", A_WM, 32'h0000_1230 | i, 1, i[0], 1, 0, 0);
      cyc("R4 legalise base", A_BS, 32'h0000_0A50 | i, 1, 0, 1, 0, 0);
      rd_both("R1 R3 readback");
    end

    cyc("R1 other csr", 12'hBC0, 32'hFFFF_FFFF, 1, 1, 1, 0, 0);
    cyc("R1 other csr", 12'hBC3, 32'h0, 0, 1, 0, 0, 0);
    for (int k = 1; k < 4; k++) begin
      cyc("R2 denied wm", A_WM, 32'h5555_5550, k[0], k[1], 0, 0, 0);
      cyc("R2 denied base", A_BS, 32'h6666_6660, k[0], k[1], 0, 0, 0);
      rd_both("R2 unchanged");
    end

    cyc("R4 base", A_BS, 32'h0000_0100, 1, 0, 1, 0, 0);
    for (int a = 32'hF0; a <= 32'h190; a++) begin
      cyc("R4 wm set", A_WM, 32'h0000_0180, 1, 0, 1, 0, 0);
      cyc("R6 R7 R8 sweep", 12'h000, 0, 0, 0, 0, 1, a);
      cyc("R6 R7 R8 result", A_WM, 0, 0, 1, 1, 0, 0);
    end

    cyc("R4 wm set", A_WM, 32'h0000_0180, 1, 0, 1, 0, 0);
    cyc("R8 base-1", 12'h000, 0, 0, 0, 0, 1, 32'h0000_00FF);
    cyc("R10 idle store", 12'h000, 0, 0, 0, 0, 0, 32'h0000_0120);
    rd_both("R8 R10 hold");

    cyc("R9 collide", A_WM, 32'h0000_0177, 1, 0, 1, 1, 32'h0000_0110);
    rd_both("R9 csr wins");
    cyc("R2 denied plus store", A_WM, 32'h0, 1, 0, 0, 1, 32'h0000_0125);
    rd_both("R2 R6 store still counts");

    cyc("R6 base hi", A_BS, 32'h0000_0010, 1, 0, 1, 0, 0);
    cyc("R6 wm hi", A_WM, 32'h8000_0100, 1, 0, 1, 0, 0);
    cyc("R6 unsigned", 12'h000, 0, 0, 0, 0, 1, 32'h8000_0005);
    rd_both("R6 R7 unsigned result");
    cyc("R8 above wm", 12'h000, 0, 0, 0, 0, 1, 32'hFFFF_FFF0);
    cyc("R8 at wm", 12'h000, 0, 0, 0, 0, 1, 32'h8000_0000);
    rd_both("R8 no change");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule